// File: doc/BRIEF.md
# Event-Triggered Descriptor DMA Engine

This block moves data between memory-mapped locations when a peripheral event fires, such as a converter signalling that a result is ready. It needs no processor involvement on each event. Each trigger line has an enable bit. When an enabled trigger fires, the engine reads that trigger's byte from a vector table at a programmable base address. That byte selects a 16-byte descriptor in memory. The engine loads the descriptor, moves one block of units, and writes the decremented count and the advanced addresses back into the descriptor. In chain mode it then goes on to the next descriptor in memory within the same activation.

While a descriptor's count has not reached its last value, the peripheral's interrupt is absorbed. On the activation whose count is 1, the engine makes the last transfer, clears the enable bit of that trigger, and forwards the interrupt. A trigger whose enable bit is clear bypasses the engine, and its interrupt goes straight out. A typical use is a converter result that is stored into a RAM buffer as halfwords and, through a chained descriptor, also has its upper byte copied into a serial transmit register.

Top module: `evt_dma`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o, en_o and irq_o are all zero.
- R2: A trigger pulse on a line whose enable bit is clear causes no bus access. It raises the matching irq_o bit for exactly one cycle, starting on the clock edge after the trigger is sampled.
- R3: An activation of trigger t first reads a byte at base_i+t. The descriptor then sits at base_i+32+16*v, where v is that byte. The descriptor is read as follows: control halfword at offset 0, block-size halfword at offset 2, count halfword at offset 4, source word at offset 8, destination word at offset 12.
- R4: In the control halfword, bit 0 selects chaining, bits 2:1 give the unit size (0 byte, 1 halfword, 2 word, 3 treated as word), bit 3 makes the source advance and bit 4 makes the destination advance. The bus size code uses the same 0/1/2 values.
- R5: Each descriptor moves N units per activation, where N is its block-size field and a field of 0 counts as 1. Each unit is a read at the source followed by a write at the destination. An advancing address steps by the unit size in bytes, and a fixed address stays put.
- R6: After its block, each descriptor gets its count minus 1 written to offset 4 (wrapping modulo 2^16), its current source written to offset 8 and its current destination written to offset 12.
- R7: With the chain bit set, the descriptor 16 bytes further on is loaded and run in the same activation with no new trigger. The final-count decision uses only the descriptor chosen by the vector byte.
- R8: When the vector-selected descriptor's count is 1 at load, the trigger's enable bit is clear and its irq_o bit is high on the cycle after done_o. Otherwise the enable bit stays set and irq_o stays low for that trigger.
- R9: Among enabled pending triggers, the lowest number is served first. A trigger that arrives while the engine is busy is held and served after the current activation.
- R10: A software write of the enable register on the same cycle as a final-count clear takes the written value for every bit except the finishing trigger's bit, which ends cleared.
- R11: A request holds its address, direction and size until acknowledged. An activation makes exactly 1 + sum over its descriptors of (5 + 2N + 3) bus transfers.
- R12: busy_o is high from the start of an activation through its done_o pulse, done_o lasts one cycle, and no request is made while busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 32 | Base address of vector table and descriptor area |
| trig_i | input | NTRIG | Peripheral event strobes, one per line |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | NTRIG | Value written to the enable register |
| en_o | output | NTRIG | Current enable bits |
| irq_o | output | NTRIG | Interrupt pulses forwarded to the processor |
| done_o | output | 1 | One-cycle pulse at the end of an activation |
| busy_o | output | 1 | Activation in progress |
| mem_req_o | output | 1 | Bus request |
| mem_we_o | output | 1 | Bus write (1) or read (0) |
| mem_size_o | output | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data, right-aligned |
| mem_rdata_i | input | 32 | Read data, right-aligned, valid with acknowledge |
| mem_ack_i | input | 1 | Transfer acknowledge |

## Verification
Two functions can land in the same cycle. One is the software write of the enable register. The other is the hardware clear of an enable bit at the end of a final-count activation. The bench provokes this by writing all ones on exactly the cycle done_o is high for a count-1 descriptor, and it passes only if en_o then shows every bit set except the finishing one. In the same way, two triggers are pulsed together, and a second trigger is pulsed while the first activation is busy. In each case the address of the first vector read of each activation shows which line was served, and in what order.

// File: rtl/evt_dma_pkg.sv
package evt_dma_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    // Control halfword bits [4:0]; packed MSB first
    typedef struct packed {
        logic       inc_dst;
        logic       inc_src;
        xfer_size_e size;
        logic       chain;
    } ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VEC,
        ST_LOAD,
        ST_READ,
        ST_WRITE,
        ST_WBACK,
        ST_DONE
    } seq_state_e;

    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int HALF_W     = 16;
    localparam int DESC_BYTES = 16;
    localparam int LOAD_LAST  = 4;
    localparam int WB_LAST    = 2;

    function automatic logic [ADDR_W-1:0] step_of(input xfer_size_e s);
        case (s)
            SZ_BYTE: return 32'd1;
            SZ_HALF: return 32'd2;
            default: return 32'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input xfer_size_e s,
                                                    input logic [DATA_W-1:0] d);
        case (s)
            SZ_BYTE: return {24'd0, d[7:0]};
            SZ_HALF: return {16'd0, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic xfer_size_e norm_size(input logic [1:0] raw);
        return (raw == 2'b11) ? SZ_WORD : xfer_size_e'(raw);
    endfunction

    // Descriptor field offset for load step 0..4
    function automatic logic [ADDR_W-1:0] load_ofs(input logic [2:0] idx);
        case (idx)
            3'd0:    return 32'd0;
            3'd1:    return 32'd2;
            3'd2:    return 32'd4;
            3'd3:    return 32'd8;
            default: return 32'd12;
        endcase
    endfunction

    function automatic xfer_size_e load_size(input logic [2:0] idx);
        return (idx < 3'd3) ? SZ_HALF : SZ_WORD;
    endfunction

endpackage

// File: rtl/evt_dma_trig.sv
module evt_dma_trig
    import evt_dma_pkg::*;
#(
    parameter int NTRIG  = 8,
    parameter int TRIG_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NTRIG-1:0]  trig_i,
    input  logic              en_wr_i,
    input  logic [NTRIG-1:0]  en_wdata_i,
    input  logic              take_i,
    input  logic [TRIG_W-1:0] take_idx_i,
    input  logic              fin_i,
    input  logic [TRIG_W-1:0] fin_idx_i,
    output logic [NTRIG-1:0]  en_o,
    output logic [NTRIG-1:0]  irq_o,
    output logic              start_valid_o,
    output logic [TRIG_W-1:0] start_idx_o
);
    logic [NTRIG-1:0] en_q, pend_q, irq_q;
    logic [NTRIG-1:0] fin_mask, take_mask, en_next, ready;

    assign fin_mask  = fin_i  ? (NTRIG'(1) << fin_idx_i)  : '0;
    assign take_mask = take_i ? (NTRIG'(1) << take_idx_i) : '0;
    assign en_next   = (en_wr_i ? en_wdata_i : en_q) & ~fin_mask;
    assign ready     = pend_q & en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            irq_q  <= '0;
        end else begin
            en_q   <= en_next;
            pend_q <= (pend_q | (trig_i & en_q)) & ~take_mask & en_next;
            irq_q  <= (trig_i & ~en_q) | fin_mask;
        end
    end

    // Lowest pending line wins
    always_comb begin
        start_valid_o = |ready;
        start_idx_o   = '0;
        for (int i = NTRIG - 1; i >= 0; i--) begin
            if (ready[i]) start_idx_o = TRIG_W'(i);
        end
    end

    assign en_o  = en_q;
    assign irq_o = irq_q;
endmodule

// File: rtl/evt_dma_seq.sv
module evt_dma_seq
    import evt_dma_pkg::*;
#(
    parameter int NTRIG    = 8,
    parameter int TRIG_W   = 3,
    parameter int DESC_OFS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              start_valid_i,
    input  logic [TRIG_W-1:0] start_idx_i,
    output logic              take_o,
    output logic              fin_o,
    output logic [TRIG_W-1:0] fin_idx_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [1:0]        mem_size_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i
);
    localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] AREA_OFS  = ADDR_W'(DESC_OFS);

    seq_state_e        st_q;
    ctl_t              ctl_q;
    logic [ADDR_W-1:0] desc_q, src_q, dst_q;
    logic [DATA_W-1:0] data_q;
    logic [HALF_W-1:0] blk_q, cnt_q;
    logic [2:0]        idx_q;
    logic [TRIG_W-1:0] cur_q;
    logic              final_q, first_q;
    logic [ADDR_W-1:0] step_w;

    assign step_w = step_of(ctl_q.size);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            ctl_q   <= '0;
            desc_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            data_q  <= '0;
            blk_q   <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            cur_q   <= '0;
            final_q <= 1'b0;
            first_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start_valid_i) begin
                    cur_q   <= start_idx_i;
                    final_q <= 1'b0;
                    st_q    <= ST_VEC;
                end
                ST_VEC: if (mem_ack_i) begin
                    desc_q  <= base_i + AREA_OFS + {20'd0, mem_rdata_i[7:0], 4'd0};
                    idx_q   <= '0;
                    first_q <= 1'b1;
                    st_q    <= ST_LOAD;
                end
                ST_LOAD: if (mem_ack_i) begin
                    case (idx_q)
                        3'd0: begin
                            ctl_q.chain   <= mem_rdata_i[0];
                            ctl_q.size    <= norm_size(mem_rdata_i[2:1]);
                            ctl_q.inc_src <= mem_rdata_i[3];
                            ctl_q.inc_dst <= mem_rdata_i[4];
                        end
                        3'd1: blk_q <= (mem_rdata_i[15:0] == '0) ? 16'd1 : mem_rdata_i[15:0];
                        3'd2: begin
                            cnt_q <= mem_rdata_i[15:0];
                            if (first_q) final_q <= (mem_rdata_i[15:0] == 16'd1);
                        end
                        3'd3: src_q <= mem_rdata_i;
                        default: dst_q <= mem_rdata_i;
                    endcase
                    if (idx_q == 3'(LOAD_LAST)) st_q <= ST_READ;
                    else idx_q <= idx_q + 3'd1;
                end
                ST_READ: if (mem_ack_i) begin
                    data_q <= lane_mask(ctl_q.size, mem_rdata_i);
                    st_q   <= ST_WRITE;
                end
                ST_WRITE: if (mem_ack_i) begin
                    if (ctl_q.inc_src) src_q <= src_q + step_w;
                    if (ctl_q.inc_dst) dst_q <= dst_q + step_w;
                    if (blk_q == 16'd1) begin
                        cnt_q <= cnt_q - 16'd1;
                        idx_q <= '0;
                        st_q  <= ST_WBACK;
                    end else begin
                        blk_q <= blk_q - 16'd1;
                        st_q  <= ST_READ;
                    end
                end
                ST_WBACK: if (mem_ack_i) begin
                    if (idx_q == 3'(WB_LAST)) begin
                        if (ctl_q.chain) begin
                            desc_q  <= desc_q + DESC_STEP;
                            idx_q   <= '0;
                            first_q <= 1'b0;
                            st_q    <= ST_LOAD;
                        end else begin
                            st_q <= ST_DONE;
                        end
                    end else begin
                        idx_q <= idx_q + 3'd1;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_size_o  = SZ_BYTE;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (st_q)
            ST_VEC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = base_i + ADDR_W'(cur_q);
            end
            ST_LOAD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_q + load_ofs(idx_q);
                mem_size_o = load_size(idx_q);
            end
            ST_READ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = src_q;
                mem_size_o = ctl_q.size;
            end
            ST_WRITE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = dst_q;
                mem_size_o  = ctl_q.size;
                mem_wdata_o = data_q;
            end
            ST_WBACK: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                case (idx_q)
                    3'd0: begin
                        mem_addr_o  = desc_q + 32'd4;
                        mem_size_o  = SZ_HALF;
                        mem_wdata_o = {16'd0, cnt_q};
                    end
                    3'd1: begin
                        mem_addr_o  = desc_q + 32'd8;
                        mem_size_o  = SZ_WORD;
                        mem_wdata_o = src_q;
                    end
                    default: begin
                        mem_addr_o  = desc_q + 32'd12;
                        mem_size_o  = SZ_WORD;
                        mem_wdata_o = dst_q;
                    end
                endcase
            end
            default: ;
        endcase
    end

    assign take_o    = (st_q == ST_IDLE) && start_valid_i;
    assign done_o    = (st_q == ST_DONE);
    assign fin_o     = (st_q == ST_DONE) && final_q;
    assign fin_idx_o = cur_q;
    assign busy_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/evt_dma.sv
module evt_dma
    import evt_dma_pkg::*;
#(
    parameter int NTRIG    = 8,
    parameter int DESC_OFS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       base_i,
    input  logic [NTRIG-1:0]  trig_i,
    input  logic              en_wr_i,
    input  logic [NTRIG-1:0]  en_wdata_i,
    output logic [NTRIG-1:0]  en_o,
    output logic [NTRIG-1:0]  irq_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [1:0]        mem_size_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic [31:0]       mem_rdata_i,
    input  logic              mem_ack_i
);
    localparam int TRIG_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;

    logic              take_w, fin_w, start_valid_w;
    logic [TRIG_W-1:0] start_idx_w, fin_idx_w;

    evt_dma_trig #(.NTRIG(NTRIG), .TRIG_W(TRIG_W)) u_trig (
        .clk           (clk),
        .rst           (rst),
        .trig_i        (trig_i),
        .en_wr_i       (en_wr_i),
        .en_wdata_i    (en_wdata_i),
        .take_i        (take_w),
        .take_idx_i    (start_idx_w),
        .fin_i         (fin_w),
        .fin_idx_i     (fin_idx_w),
        .en_o          (en_o),
        .irq_o         (irq_o),
        .start_valid_o (start_valid_w),
        .start_idx_o   (start_idx_w)
    );

    evt_dma_seq #(.NTRIG(NTRIG), .TRIG_W(TRIG_W), .DESC_OFS(DESC_OFS)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .base_i        (base_i),
        .start_valid_i (start_valid_w),
        .start_idx_i   (start_idx_w),
        .take_o        (take_w),
        .fin_o         (fin_w),
        .fin_idx_o     (fin_idx_w),
        .done_o        (done_o),
        .busy_o        (busy_o),
        .mem_req_o     (mem_req_o),
        .mem_we_o      (mem_we_o),
        .mem_size_o    (mem_size_o),
        .mem_addr_o    (mem_addr_o),
        .mem_wdata_o   (mem_wdata_o),
        .mem_rdata_i   (mem_rdata_i),
        .mem_ack_i     (mem_ack_i)
    );
endmodule

// File: rtl/evt_dma_chk.sv
module evt_dma_chk #(
    parameter int NTRIG  = 8,
    parameter int TRIG_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              req,
    input logic              we,
    input logic [1:0]        size,
    input logic [31:0]       addr,
    input logic              ack,
    input logic [NTRIG-1:0]  en,
    input logic              en_wr,
    input logic [NTRIG-1:0]  irq,
    input logic              fin,
    input logic [TRIG_W-1:0] fin_idx
);
    logic [NTRIG-1:0] fin_mask;
    assign fin_mask = fin ? (NTRIG'(1) << fin_idx) : '0;

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !req);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(addr) && $stable(we) && $stable(size)));

    // R10
    en_set_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> ((en & ~$past(en)) == '0));

    // R8
    final_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> ((en & $past(fin_mask)) == '0));

    // R8
    final_irq_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> ((irq & $past(fin_mask)) == $past(fin_mask)));
endmodule

bind evt_dma evt_dma_chk #(.NTRIG(NTRIG), .TRIG_W(TRIG_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy_o),
    .done    (done_o),
    .req     (mem_req_o),
    .we      (mem_we_o),
    .size    (mem_size_o),
    .addr    (mem_addr_o),
    .ack     (mem_ack_i),
    .en      (en_o),
    .en_wr   (en_wr_i),
    .irq     (irq_o),
    .fin     (fin_w),
    .fin_idx (fin_idx_w)
);

// File: tb/sim_evt_dma.sv
`timescale 1ns/1ps
module sim_evt_dma;
    localparam int NT   = 8;
    localparam int BASE = 32'h100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   base_i = BASE;
    logic [NT-1:0] trig = '0;
    logic          en_wr = 1'b0;
    logic [NT-1:0] en_wdata = '0;
    logic [NT-1:0] en_o, irq_o;
    logic          done_o, busy_o, mem_req_o, mem_we_o;
    logic [1:0]    mem_size_o;
    logic [31:0]   mem_addr_o, mem_wdata_o;
    logic [31:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0;

    int tests = 0;
    int fails = 0;
    bit ended = 0;
    int resp_cnt = 0;
    logic [31:0] addr_log [0:63];
    logic [7:0]  mem [0:1023];

    always #10 clk = ~clk;

    evt_dma #(.NTRIG(NT)) u0 (
        .clk(clk), .rst(rst), .base_i(base_i), .trig_i(trig),
        .en_wr_i(en_wr), .en_wdata_i(en_wdata), .en_o(en_o), .irq_o(irq_o),
        .done_o(done_o), .busy_o(busy_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_size_o(mem_size_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
    );

    // Bus responder: one acknowledge per request, two cycles per transfer
    initial begin
        int a;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req_o && !rst) begin
                a = int'(mem_addr_o[9:0]);
                if (resp_cnt < 64) addr_log[resp_cnt] = mem_addr_o;
                resp_cnt++;
                if (mem_we_o) begin
                    mem[a] = mem_wdata_o[7:0];
                    if (mem_size_o >= 2'd1) mem[(a+1)&1023] = mem_wdata_o[15:8];
                    if (mem_size_o >= 2'd2) begin
                        mem[(a+2)&1023] = mem_wdata_o[23:16];
                        mem[(a+3)&1023] = mem_wdata_o[31:24];
                    end
                end else begin
                    mem_rdata = {24'd0, mem[a]};
                    if (mem_size_o >= 2'd1) mem_rdata[15:8] = mem[(a+1)&1023];
                    if (mem_size_o >= 2'd2) begin
                        mem_rdata[23:16] = mem[(a+2)&1023];
                        mem_rdata[31:24] = mem[(a+3)&1023];
                    end
                end
                mem_ack = 1'b1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put16(input int a, input logic [15:0] v);
        mem[a] = v[7:0]; mem[a+1] = v[15:8];
    endtask

    task automatic put32(input int a, input logic [31:0] v);
        put16(a, v[15:0]); put16(a+2, v[31:16]);
    endtask

    function automatic logic [15:0] get16(input int a);
        return {mem[a+1], mem[a]};
    endfunction

    function automatic logic [31:0] get32(input int a);
        return {get16(a+2), get16(a)};
    endfunction

    task automatic set_desc(input int a, input logic [15:0] ctl, input logic [15:0] blk,
                            input logic [15:0] cnt, input logic [31:0] s, input logic [31:0] d);
        put16(a, ctl); put16(a+2, blk); put16(a+4, cnt); put32(a+8, s); put32(a+12, d);
    endtask

    task automatic set_en(input logic [NT-1:0] m);
        @(negedge clk); en_wr = 1'b1; en_wdata = m;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic pulse(input logic [NT-1:0] m);
        @(negedge clk); trig = m;
        @(negedge clk); trig = '0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done_o && n < 4000) begin @(negedge clk); n++; end
        if (!done_o) chk({tag, " done timeout"}, 0, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            tests++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] expb [0:63];
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy_o}, 0);
        chk("R1 req", {31'd0, mem_req_o}, 0);
        chk("R1 done", {31'd0, done_o}, 0);
        chk("R1 en", {24'd0, en_o}, 0);
        chk("R1 irq", {24'd0, irq_o}, 0);

        // R2 disabled trigger bypasses the engine
        resp_cnt = 0;
        @(negedge clk); trig = 8'h10;
        @(negedge clk); trig = '0;
        chk("R2 irq pulse", {24'd0, irq_o}, 32'h10);
        @(negedge clk);
        chk("R2 irq single", {24'd0, irq_o}, 0);
        chk("R2 no bus", resp_cnt, 0);
        chk("R2 idle", {31'd0, busy_o}, 0);

        // R3 R4 R5 R6 R11 sweep over size, increments and block size
        mem[BASE+1] = 8'd3;
        set_en(8'h02);
        for (int sz = 0; sz < 3; sz++)
        for (int is = 0; is < 2; is++)
        for (int id = 0; id < 2; id++)
        for (int b = 0; b < 4; b++) begin
            int da, nb, st, bad, s, d;
            da = BASE + 32 + 16*3;
            nb = (b == 0) ? 1 : b;
            st = 1 << sz;
            set_desc(da, 16'((id << 4) | (is << 3) | (sz << 1)), 16'(b), 16'd5,
                     32'h200, 32'h280);
            for (int k = 0; k < 32; k++) mem[32'h200+k] = 8'((sz*7 + k*13 + b*29 + is + id*3) & 255);
            for (int k = 0; k < 64; k++) begin mem[32'h280+k] = 8'h00; expb[k] = 8'h00; end
            for (int k = 0; k < nb; k++) begin
                s = 32'h200 + (is ? k*st : 0);
                d = (id ? k*st : 0);
                for (int j = 0; j < st; j++) expb[d+j] = mem[s+j];
            end
            resp_cnt = 0;
            pulse(8'h02);
            wait_done("R5 sweep");
            bad = 0;
            for (int k = 0; k < 64; k++) if (mem[32'h280+k] !== expb[k]) bad++;
            chk("R5 R4 block data mismatches", bad, 0);
            chk("R11 bus transfers", resp_cnt, 1 + 5 + 2*nb + 3);
            chk("R3 vector read address", addr_log[0], BASE + 1);
            chk("R3 descriptor address", addr_log[1], da);
            chk("R6 count writeback", {16'd0, get16(da+4)}, 32'd4);
            chk("R6 source writeback", get32(da+8), 32'h200 + (is ? nb*st : 0));
            chk("R6 dest writeback", get32(da+12), 32'h280 + (id ? nb*st : 0));
            @(negedge clk);
            chk("R8 not final keeps enable", {24'd0, en_o}, 32'h02);
            chk("R8 not final absorbs irq", {24'd0, irq_o}, 0);
        end
        set_en(8'h00);

        // R7 R8 chain: halfword result to RAM, upper byte to transmit register
        mem[BASE+5] = 8'd5;
        set_desc(BASE + 32 + 16*5, 16'h0013, 16'd1, 16'd40, 32'h3F0, 32'h300);
        set_desc(BASE + 32 + 16*6, 16'h0000, 16'd1, 16'd0,  32'h3F1, 32'h3F8);
        for (int k = 0; k < 80; k++) mem[32'h300+k] = 8'h00;
        set_en(8'h20);
        for (int t = 0; t < 40; t++) begin
            logic [15:0] v;
            v = 16'h1234 + 16'(t * 16'h0101);
            put16(32'h3F0, v);
            resp_cnt = 0;
            pulse(8'h20);
            wait_done("R7 chain");
            chk("R11 chained transfers", resp_cnt, 1 + 2*(5 + 2 + 3));
            chk("R7 chained byte copy", {24'd0, mem[32'h3F8]}, {24'd0, v[15:8]});
            @(negedge clk);
            chk("R8 irq on final only", {31'd0, irq_o[5]}, (t == 39) ? 1 : 0);
            chk("R8 enable until final", {31'd0, en_o[5]}, (t == 39) ? 0 : 1);
        end
        begin
            int bad = 0;
            for (int t = 0; t < 40; t++)
                if (get16(32'h300 + 2*t) !== 16'h1234 + 16'(t * 16'h0101)) bad++;
            chk("R5 halfword fill of 80 bytes", bad, 0);
        end
        chk("R6 first count ends at 0", {16'd0, get16(BASE+32+16*5+4)}, 0);
        chk("R6 first dest advanced", get32(BASE+32+16*5+12), 32'h350);
        chk("R7 chained count wraps", {16'd0, get16(BASE+32+16*6+4)}, 32'hFFD8);
        chk("R5 fixed source kept", get32(BASE+32+16*6+8), 32'h3F1);
        resp_cnt = 0;
        @(negedge clk); trig = 8'h20;
        @(negedge clk); trig = '0;
        chk("R2 after final irq passes", {24'd0, irq_o}, 32'h20);
        @(negedge clk);
        chk("R2 after final no bus", resp_cnt, 0);

        // R9 simultaneous triggers: lowest first
        mem[BASE+0] = 8'd7;
        mem[BASE+2] = 8'd8;
        set_desc(BASE + 32 + 16*7, 16'h0000, 16'd1, 16'd9, 32'h3E0, 32'h3E4);
        set_desc(BASE + 32 + 16*8, 16'h0000, 16'd1, 16'd9, 32'h3E1, 32'h3E5);
        mem[32'h3E0] = 8'hA5; mem[32'h3E1] = 8'h5A;
        mem[32'h3E4] = 8'h00; mem[32'h3E5] = 8'h00;
        set_en(8'h05);
        resp_cnt = 0;
        pulse(8'h05);
        wait_done("R9 first");
        chk("R9 lowest served first", addr_log[0], BASE + 0);
        resp_cnt = 0;
        @(negedge clk);
        wait_done("R9 second");
        chk("R9 second served next", addr_log[0], BASE + 2);
        chk("R9 both copies", {16'd0, mem[32'h3E5], mem[32'h3E4]}, 32'h5AA5);

        // R9 trigger held while busy
        resp_cnt = 0;
        pulse(8'h01);
        @(negedge clk);
        chk("R12 busy during activation", {31'd0, busy_o}, 1);
        trig = 8'h04;
        @(negedge clk); trig = '0;
        wait_done("R9 busy first");
        chk("R9 busy first line", addr_log[0], BASE + 0);
        resp_cnt = 0;
        @(negedge clk);
        chk("R12 done one cycle", {31'd0, done_o}, 0);
        wait_done("R9 held");
        chk("R9 held trigger served", addr_log[0], BASE + 2);
        @(negedge clk);
        @(negedge clk);
        chk("R12 idle after", {31'd0, busy_o}, 0);

        // R10 enable write on the same cycle as the final clear
        mem[BASE+3] = 8'd9;
        set_desc(BASE + 32 + 16*9, 16'h0000, 16'd0, 16'd1, 32'h3E0, 32'h3E6);
        set_en(8'h08);
        pulse(8'h08);
        wait_done("R10");
        en_wr = 1'b1; en_wdata = 8'hFF;
        @(negedge clk); en_wr = 1'b0;
        chk("R10 write with final clear", {24'd0, en_o}, 32'hF7);
        chk("R8 final irq", {24'd0, irq_o}, 32'h08);
        chk("R6 final count 0", {16'd0, get16(BASE+32+16*9+4)}, 0);
        set_en(8'h00);

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule